// File: doc/BRIEF.md
# Word/Byte ALU with Condition Codes

This block is the arithmetic and logic stage of a 16-bit processor. It takes two operands that have already been fetched, a destination and a source, plus an operation code. In the same cycle it produces the value to write back, a strobe saying whether that value should be written, and the condition codes the operation would leave behind. The condition codes are kept in a four-bit register inside the block. Bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. The register loads the next value on a clock edge when the caller enables flag writing.

The block covers every two-operand and one-operand operation. A byte-mode flag narrows both the operation and its flags to the low eight bits. A separate condition-code command sets or clears any chosen group of the four flags in one step. Operand fetch, address arithmetic for write-back, multiply, divide and floating point are handled elsewhere.

Top module: `wordByteAlu`

## Requirements
- R1: `opSel` selects the two-operand operations. 0 copies the source. 1 compares, computing destination minus source. 2 tests bits with destination AND source. 3 clears bits with destination AND NOT source. 4 sets bits with destination OR source. 5 adds. 6 subtracts, computing destination minus source.
- R2: For add (5), subtract (6) and compare (1), C is the carry out of the top bit for add and the borrow for subtract and compare. V is set on signed overflow. For subtract and compare that means the operands had different signs and the result has the source's sign. For add it means the operands had the same sign and the result has the other sign.
- R3: Copy, bit test, bit clear and bit set clear V and leave C as it was.
- R4: Every ALU operation sets N to the top bit of the active width and sets Z when the active-width result is zero.
- R5: Codes 8 to 15 are clear, complement, increment, decrement, negate, add-carry, subtract-carry and test, all acting on the destination. Clear gives C=0 and V=0. Complement gives C=1 and V=0. Increment and decrement keep C and set V on signed overflow. Negate sets C when the result is non-zero and sets V when the result is the most negative value. Add-carry and subtract-carry set C on carry out or borrow and V on overflow. Test gives V=0 and C=0.
- R6: Codes 16 to 19 are rotate right and rotate left, both through C, then arithmetic shift right, which keeps the sign bit, and shift left, which fills bit 0 with zero. The bit shifted out goes to C, and V = N XOR C afterwards.
- R7: Code 20 swaps the two bytes of the destination. It ignores byte mode, takes N and Z from the new low byte, and clears V and C.
- R8: With `byteMode` high, every operation except the swap uses only bits 7..0 of each operand for its result and flags. `result[15:8]` passes `dstIn[15:8]` through unchanged.
- R9: Compare, bit test and test drive `resultWe` low. The unused codes (7 and 21..31) also drive `resultWe` low and leave `ccNext` equal to `ccFlags`.
- R10: When `ccOp` is high, the code on `opSel` is ignored and `resultWe` is low. In `ccWord`, bit 4 picks set (1) or clear (0), and bits 3..0 mask N, Z, V and C in that order. Every masked flag in `ccNext` takes the chosen value, and every unmasked flag keeps its `ccFlags` value.
- R11: `ccFlags` resets to 0000. It loads `ccNext` on a rising clock when `flagWe` or `ccOp` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 5 | Operation code |
| srcIn | input | 16 | Source operand |
| dstIn | input | 16 | Destination operand |
| byteMode | input | 1 | Restrict the operation to the low byte |
| flagWe | input | 1 | Load the flag register at the next edge |
| ccOp | input | 1 | Run the condition-code command instead of `opSel` |
| ccWord | input | 5 | Set/clear choice (bit 4) and flag mask (bits 3..0) |
| result | output | 16 | Value to write back |
| resultWe | output | 1 | Write-back strobe |
| ccNext | output | 4 | Condition codes after this operation |
| ccFlags | output | 4 | Registered condition codes {N,Z,V,C} |

## Verification
The assertions assume that `opSel`, `byteMode`, `ccOp` and `ccWord` stay steady between clock edges. They also assume that whatever `flagWe` or `ccOp` shows at an edge is what the caller meant to commit. The stimulus meets both conditions by changing every input only at the falling edge. The bench sends unused operation codes and condition-code commands mixed in with normal operations, so the checks on flag holding and write suppression are exercised together with the arithmetic.

// File: rtl/wbAluPkg.sv
package wbAluPkg;

  typedef enum logic [4:0] {
    OP_MOV  = 5'd0,
    OP_CMP  = 5'd1,
    OP_BIT  = 5'd2,
    OP_BIC  = 5'd3,
    OP_BIS  = 5'd4,
    OP_ADD  = 5'd5,
    OP_SUB  = 5'd6,
    OP_CLR  = 5'd8,
    OP_COM  = 5'd9,
    OP_INC  = 5'd10,
    OP_DEC  = 5'd11,
    OP_NEG  = 5'd12,
    OP_ADC  = 5'd13,
    OP_SBC  = 5'd14,
    OP_TST  = 5'd15,
    OP_ROR  = 5'd16,
    OP_ROL  = 5'd17,
    OP_ASR  = 5'd18,
    OP_ASL  = 5'd19,
    OP_SWAB = 5'd20
  } aluOp_e;

  // result source
  typedef enum logic [3:0] {
    RS_ADD, RS_AND, RS_BIC, RS_OR, RS_SRC, RS_DST, RS_COM, RS_ZERO,
    RS_ROR, RS_ROL, RS_ASR, RS_ASL, RS_SWAB
  } resSel_e;

  // second adder input
  typedef enum logic [2:0] {
    AB_SRC, AB_NSRC, AB_ZERO, AB_ONES, AB_NDST
  } addB_e;

  typedef enum logic [1:0] {
    CI_ZERO, CI_ONE, CI_CARRY, CI_NCARRY
  } cin_e;

  typedef enum logic [1:0] {
    VS_CLR, VS_ARITH, VS_NXORC
  } vSel_e;

  typedef enum logic [2:0] {
    CS_KEEP, CS_CLR, CS_SET, CS_COUT, CS_NCOUT, CS_LSB, CS_MSB, CS_NONZ
  } cSel_e;

  typedef struct packed {
    resSel_e resSel;
    logic    addAZero;
    addB_e   addB;
    cin_e    cin;
    vSel_e   vSel;
    cSel_e   cSel;
    logic    lowByteFlags;
    logic    ignoreByte;
    logic    writeRes;
    logic    keepFlags;
    logic    ccInstr;
  } aluStrobe_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import wbAluPkg::*;
(
  input  logic [4:0]  opSel,
  input  logic        ccOp,
  output aluStrobe_t  strobe
);

  always_comb begin
    strobe              = '0;
    strobe.resSel       = RS_DST;
    strobe.addB         = AB_ZERO;
    strobe.cin          = CI_ZERO;
    strobe.vSel         = VS_CLR;
    strobe.cSel         = CS_KEEP;
    strobe.keepFlags    = 1'b1;
    if (ccOp) begin
      strobe.ccInstr   = 1'b1;
      strobe.keepFlags = 1'b0;
    end else begin
      strobe.keepFlags = 1'b0;
      strobe.writeRes  = 1'b1;
      case (opSel)
        OP_MOV: strobe.resSel = RS_SRC;
        OP_CMP: begin
          strobe.resSel   = RS_ADD;
          strobe.addB     = AB_NSRC;
          strobe.cin      = CI_ONE;
          strobe.vSel     = VS_ARITH;
          strobe.cSel     = CS_NCOUT;
          strobe.writeRes = 1'b0;
        end
        OP_BIT: begin
          strobe.resSel   = RS_AND;
          strobe.writeRes = 1'b0;
        end
        OP_BIC: strobe.resSel = RS_BIC;
        OP_BIS: strobe.resSel = RS_OR;
        OP_ADD: begin
          strobe.resSel = RS_ADD;
          strobe.addB   = AB_SRC;
          strobe.vSel   = VS_ARITH;
          strobe.cSel   = CS_COUT;
        end
        OP_SUB: begin
          strobe.resSel = RS_ADD;
          strobe.addB   = AB_NSRC;
          strobe.cin    = CI_ONE;
          strobe.vSel   = VS_ARITH;
          strobe.cSel   = CS_NCOUT;
        end
        OP_CLR: begin
          strobe.resSel = RS_ZERO;
          strobe.cSel   = CS_CLR;
        end
        OP_COM: begin
          strobe.resSel = RS_COM;
          strobe.cSel   = CS_SET;
        end
        OP_INC: begin
          strobe.resSel = RS_ADD;
          strobe.cin    = CI_ONE;
          strobe.vSel   = VS_ARITH;
        end
        OP_DEC: begin
          strobe.resSel = RS_ADD;
          strobe.addB   = AB_ONES;
          strobe.vSel   = VS_ARITH;
        end
        OP_NEG: begin
          strobe.resSel   = RS_ADD;
          strobe.addAZero = 1'b1;
          strobe.addB     = AB_NDST;
          strobe.cin      = CI_ONE;
          strobe.vSel     = VS_ARITH;
          strobe.cSel     = CS_NONZ;
        end
        OP_ADC: begin
          strobe.resSel = RS_ADD;
          strobe.cin    = CI_CARRY;
          strobe.vSel   = VS_ARITH;
          strobe.cSel   = CS_COUT;
        end
        OP_SBC: begin
          strobe.resSel = RS_ADD;
          strobe.addB   = AB_ONES;
          strobe.cin    = CI_NCARRY;
          strobe.vSel   = VS_ARITH;
          strobe.cSel   = CS_NCOUT;
        end
        OP_TST: begin
          strobe.resSel   = RS_DST;
          strobe.cSel     = CS_CLR;
          strobe.writeRes = 1'b0;
        end
        OP_ROR: begin
          strobe.resSel = RS_ROR;
          strobe.vSel   = VS_NXORC;
          strobe.cSel   = CS_LSB;
        end
        OP_ROL: begin
          strobe.resSel = RS_ROL;
          strobe.vSel   = VS_NXORC;
          strobe.cSel   = CS_MSB;
        end
        OP_ASR: begin
          strobe.resSel = RS_ASR;
          strobe.vSel   = VS_NXORC;
          strobe.cSel   = CS_LSB;
        end
        OP_ASL: begin
          strobe.resSel = RS_ASL;
          strobe.vSel   = VS_NXORC;
          strobe.cSel   = CS_MSB;
        end
        OP_SWAB: begin
          strobe.resSel       = RS_SWAB;
          strobe.ignoreByte   = 1'b1;
          strobe.lowByteFlags = 1'b1;
          strobe.cSel         = CS_CLR;
        end
        default: begin
          strobe.writeRes  = 1'b0;
          strobe.keepFlags = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import wbAluPkg::*;
#(
  parameter int DataW = 16
) (
  input  aluStrobe_t        strobe,
  input  logic [DataW-1:0]  srcIn,
  input  logic [DataW-1:0]  dstIn,
  input  logic              byteMode,
  input  logic [3:0]        ccCur,
  input  logic [4:0]        ccWord,
  output logic [DataW-1:0]  result,
  output logic [3:0]        ccNext
);

  localparam int LaneW = DataW / 2;
  localparam logic [DataW-1:0] WordMask = {DataW{1'b1}};
  localparam logic [DataW-1:0] LowMask  = {{LaneW{1'b0}}, {LaneW{1'b1}}};
  localparam logic [DataW-1:0] WordMsb  = {1'b1, {(DataW-1){1'b0}}};
  localparam logic [DataW-1:0] LaneMsb  = {{LaneW{1'b0}}, 1'b1, {(LaneW-1){1'b0}}};

  logic              narrow, flagNarrow;
  logic [DataW-1:0]  laneMask, msbMask, srcM, dstM, aOp, bOp, rawRes;
  logic [DataW:0]    sum;
  logic              cinBit, cout, carryIn;
  logic              aMsb, bMsb, rMsb, dMsb;
  logic              nFlag, zFlag, vFlag, cFlag;

  assign carryIn  = ccCur[0];
  assign narrow   = byteMode & ~strobe.ignoreByte;
  assign laneMask = narrow ? LowMask : WordMask;
  assign msbMask  = narrow ? LaneMsb : WordMsb;
  assign srcM     = srcIn & laneMask;
  assign dstM     = dstIn & laneMask;

  // shared adder
  always_comb begin
    aOp = strobe.addAZero ? '0 : dstM;
    case (strobe.addB)
      AB_SRC:  bOp = srcM;
      AB_NSRC: bOp = ~srcM & laneMask;
      AB_ONES: bOp = laneMask;
      AB_NDST: bOp = ~dstM & laneMask;
      default: bOp = '0;
    endcase
    case (strobe.cin)
      CI_ONE:    cinBit = 1'b1;
      CI_CARRY:  cinBit = carryIn;
      CI_NCARRY: cinBit = ~carryIn;
      default:   cinBit = 1'b0;
    endcase
  end

  assign sum  = {1'b0, aOp} + {1'b0, bOp} + {{DataW{1'b0}}, cinBit};
  assign cout = narrow ? sum[LaneW] : sum[DataW];
  assign aMsb = |(aOp & msbMask);
  assign bMsb = |(bOp & msbMask);
  assign dMsb = |(dstM & msbMask);

  // result select
  always_comb begin
    case (strobe.resSel)
      RS_ADD:  rawRes = sum[DataW-1:0] & laneMask;
      RS_AND:  rawRes = dstM & srcM;
      RS_BIC:  rawRes = dstM & ~srcM;
      RS_OR:   rawRes = dstM | srcM;
      RS_SRC:  rawRes = srcM;
      RS_COM:  rawRes = ~dstM & laneMask;
      RS_ZERO: rawRes = '0;
      RS_ROR:  rawRes = (dstM >> 1) | (carryIn ? msbMask : '0);
      RS_ROL:  rawRes = {dstM[DataW-2:0], carryIn} & laneMask;
      RS_ASR:  rawRes = (dstM >> 1) | (dMsb ? msbMask : '0);
      RS_ASL:  rawRes = {dstM[DataW-2:0], 1'b0} & laneMask;
      RS_SWAB: rawRes = {dstIn[LaneW-1:0], dstIn[DataW-1:LaneW]};
      default: rawRes = dstM;
    endcase
  end

  assign result = narrow ? {dstIn[DataW-1:LaneW], rawRes[LaneW-1:0]} : rawRes;

  // flag generation
  assign flagNarrow = narrow | strobe.lowByteFlags;
  assign rMsb  = |(rawRes & msbMask);
  assign nFlag = flagNarrow ? rawRes[LaneW-1] : rawRes[DataW-1];
  assign zFlag = flagNarrow ? (rawRes[LaneW-1:0] == '0) : (rawRes == '0);

  always_comb begin
    case (strobe.cSel)
      CS_CLR:   cFlag = 1'b0;
      CS_SET:   cFlag = 1'b1;
      CS_COUT:  cFlag = cout;
      CS_NCOUT: cFlag = ~cout;
      CS_LSB:   cFlag = dstM[0];
      CS_MSB:   cFlag = dMsb;
      CS_NONZ:  cFlag = ~zFlag;
      default:  cFlag = carryIn;
    endcase
    case (strobe.vSel)
      VS_ARITH: vFlag = (aMsb == bMsb) && (rMsb != aMsb);
      VS_NXORC: vFlag = nFlag ^ cFlag;
      default:  vFlag = 1'b0;
    endcase
  end

  // condition-code command, one mux per flag
  logic [3:0] ccCmd;
  for (genvar g = 0; g < 4; g++) begin : gCcBit
    assign ccCmd[g] = ccWord[g] ? ccWord[4] : ccCur[g];
  end

  always_comb begin
    if (strobe.ccInstr)        ccNext = ccCmd;
    else if (strobe.keepFlags) ccNext = ccCur;
    else                       ccNext = {nFlag, zFlag, vFlag, cFlag};
  end

endmodule

// File: rtl/wordByteAlu.sv
module wordByteAlu
  import wbAluPkg::*;
#(
  parameter int DataW = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [4:0]       opSel,
  input  logic [DataW-1:0] srcIn,
  input  logic [DataW-1:0] dstIn,
  input  logic             byteMode,
  input  logic             flagWe,
  input  logic             ccOp,
  input  logic [4:0]       ccWord,
  output logic [DataW-1:0] result,
  output logic             resultWe,
  output logic [3:0]       ccNext,
  output logic [3:0]       ccFlags
);

  aluStrobe_t strobe;

  aluCtrl uCtrl (
    .opSel  (opSel),
    .ccOp   (ccOp),
    .strobe (strobe)
  );

  aluDatapath #(.DataW(DataW)) uDp (
    .strobe   (strobe),
    .srcIn    (srcIn),
    .dstIn    (dstIn),
    .byteMode (byteMode),
    .ccCur    (ccFlags),
    .ccWord   (ccWord),
    .result   (result),
    .ccNext   (ccNext)
  );

  assign resultWe = strobe.writeRes;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                ccFlags <= 4'b0000;
    else if (flagWe || ccOp)  ccFlags <= ccNext;
  end

endmodule

// File: rtl/aluChecker.sv
module aluChecker
  import wbAluPkg::*;
#(
  parameter int DataW = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [4:0]       opSel,
  input logic             byteMode,
  input logic             flagWe,
  input logic             ccOp,
  input logic [4:0]       ccWord,
  input logic [DataW-1:0] dstIn,
  input logic [DataW-1:0] result,
  input logic             resultWe,
  input logic [3:0]       ccNext,
  input logic [3:0]       ccFlags
);

  localparam int LaneW = DataW / 2;

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!flagWe && !ccOp) |=> $stable(ccFlags)); // R11

  AST_CC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe || ccOp) |=> (ccFlags == $past(ccNext))); // R11

  AST_NO_WRITEBACK: assert property (@(posedge clk) disable iff (!rstN)
    (ccOp || opSel == OP_CMP || opSel == OP_BIT || opSel == OP_TST) |-> !resultWe); // R9

  AST_UNUSED_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    (!ccOp && (opSel == 5'd7 || opSel > OP_SWAB)) |-> (ccNext == ccFlags && !resultWe)); // R9

  AST_BYTE_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!ccOp && byteMode && opSel != OP_SWAB && resultWe)
      |-> (result[DataW-1:LaneW] == dstIn[DataW-1:LaneW])); // R8

  AST_CC_MASK_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    ccOp |-> (((ccNext ^ ccFlags) & ~ccWord[3:0]) == 4'b0000)); // R10

  AST_CC_MASK_APPLY: assert property (@(posedge clk) disable iff (!rstN)
    ccOp |-> ((ccNext & ccWord[3:0]) == (ccWord[4] ? ccWord[3:0] : 4'b0000))); // R10

  AST_LOGIC_V_C: assert property (@(posedge clk) disable iff (!rstN)
    (!ccOp && (opSel == OP_MOV || opSel == OP_BIT || opSel == OP_BIC || opSel == OP_BIS))
      |-> (!ccNext[1] && ccNext[0] == ccFlags[0])); // R3

  AST_WORD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (!ccOp && !byteMode && resultWe && opSel != OP_SWAB)
      |-> (ccNext[2] == (result == '0) && ccNext[3] == result[DataW-1])); // R4

endmodule

bind wordByteAlu aluChecker #(.DataW(DataW)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .opSel    (opSel),
  .byteMode (byteMode),
  .flagWe   (flagWe),
  .ccOp     (ccOp),
  .ccWord   (ccWord),
  .dstIn    (dstIn),
  .result   (result),
  .resultWe (resultWe),
  .ccNext   (ccNext),
  .ccFlags  (ccFlags)
);

// File: tb/sim_wordByteAlu.sv
module sim_wordByteAlu;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opSel = '0;
  logic [15:0] srcIn = '0;
  logic [15:0] dstIn = '0;
  logic        byteMode = 1'b0;
  logic        flagWe = 1'b0;
  logic        ccOp = 1'b0;
  logic [4:0]  ccWord = '0;
  logic [15:0] result;
  logic        resultWe;
  logic [3:0]  ccNext;
  logic [3:0]  ccFlags;

  int errors = 0;
  int checks = 0;
  bit [3:0] mCc = 4'b0000;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wordByteAlu #(.DataW(16)) u0 (
    .clk(clk), .rstN(rstN), .opSel(opSel), .srcIn(srcIn), .dstIn(dstIn),
    .byteMode(byteMode), .flagWe(flagWe), .ccOp(ccOp), .ccWord(ccWord),
    .result(result), .resultWe(resultWe), .ccNext(ccNext), .ccFlags(ccFlags)
  );

  // behavioural reference
  function automatic void refModel(input int op, input int src, input int dst,
                                   input bit bm, input bit cop, input bit [4:0] ccw,
                                   input bit [3:0] cc, output int res,
                                   output bit we, output bit [3:0] nx);
    int mask, msb, d, s, r, t, ci;
    bit n, z, v, c, keep;
    mask = (bm && op != 20) ? 'hFF : 'hFFFF;
    msb  = (mask == 'hFF) ? 'h80 : 'h8000;
    d = dst & mask; s = src & mask; ci = cc[0];
    c = cc[0]; v = 0; we = 1; keep = 0; r = 0;
    case (op)
      0: r = s;
      1, 6: begin
        r = (d - s + mask + 1) & mask; c = d < s;
        v = (((d ^ s) & msb) != 0) && (((r ^ s) & msb) == 0);
        we = (op == 6);
      end
      2: begin r = d & s; we = 0; end
      3: r = d & ~s & mask;
      4: r = d | s;
      5: begin
        t = d + s; r = t & mask; c = t > mask;
        v = (((d ^ s) & msb) == 0) && (((r ^ d) & msb) != 0);
      end
      8: begin r = 0; c = 0; end
      9: begin r = ~d & mask; c = 1; end
      10: begin r = (d + 1) & mask; v = (d == msb - 1); end
      11: begin r = (d + mask) & mask; v = (d == msb); end
      12: begin r = (mask + 1 - d) & mask; v = (r == msb); c = (r != 0); end
      13: begin r = (d + ci) & mask; v = ci && d == msb - 1; c = ci && d == mask; end
      14: begin r = (d + mask + 1 - ci) & mask; v = ci && d == msb; c = ci && d == 0; end
      15: begin r = d; c = 0; we = 0; end
      16: begin r = (d >> 1) | (ci ? msb : 0); c = d & 1; end
      17: begin r = ((d << 1) & mask) | ci; c = (d & msb) != 0; end
      18: begin r = (d >> 1) | (d & msb); c = d & 1; end
      19: begin r = (d << 1) & mask; c = (d & msb) != 0; end
      20: begin r = ((dst & 'hFF) << 8) | ((dst >> 8) & 'hFF); c = 0; end
      default: begin we = 0; keep = 1; end
    endcase
    n = (r & (op == 20 ? 'h80 : msb)) != 0;
    z = ((op == 20) ? (r & 'hFF) : r) == 0;
    if (op >= 16 && op <= 19) v = n ^ c;
    nx = keep ? cc : {n, z, v, c};
    res = (mask == 'hFF) ? ((dst & 'hFF00) | r) : r;
    if (cop) begin
      we = 0;
      nx = ccw[4] ? (cc | ccw[3:0]) : (cc & ~ccw[3:0]);
    end
  endfunction

  function automatic string flagTag(input int op, input bit bm, input bit cop);
    if (cop) return "R10";
    if (op == 20) return "R7";
    if (bm && (op <= 6 || (op >= 8 && op <= 19))) return "R8";
    if (op == 1 || op == 5 || op == 6) return "R2";
    if (op == 0 || op == 2 || op == 3 || op == 4) return "R3";
    if (op >= 16 && op <= 19) return "R6";
    if (op >= 8 && op <= 15) return "R5";
    return "R9";
  endfunction

  function automatic string resTag(input int op, input bit bm);
    if (op == 20) return "R7";
    if (bm) return "R8";
    if (op <= 6) return "R1";
    if (op >= 16) return "R6";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic applyVec(input int op, input int src, input int dst, input bit bm,
                          input bit fwe, input bit cop, input bit [4:0] ccw);
    int expRes; bit expWe; bit [3:0] expNx;
    @(negedge clk);
    opSel = op[4:0]; srcIn = src[15:0]; dstIn = dst[15:0];
    byteMode = bm; flagWe = fwe; ccOp = cop; ccWord = ccw;
    #1;
    refModel(op, src & 'hFFFF, dst & 'hFFFF, bm, cop, ccw, mCc, expRes, expWe, expNx);
    check(ccFlags == mCc, "R11", "ccFlags", ccFlags, mCc);
    check(resultWe == expWe, "R9", "resultWe", resultWe, expWe);
    if (expWe)
      check(result == expRes[15:0], resTag(op, bm), "result", result, expRes);
    if (cop || (op >= 7 && op != 20 && (op == 7 || op > 20)))
      check(ccNext == expNx, flagTag(op, bm, cop), "ccNext", ccNext, expNx);
    else begin
      check(ccNext[3:2] == expNx[3:2], "R4", "N,Z", ccNext[3:2], expNx[3:2]);
      check(ccNext[1:0] == expNx[1:0], flagTag(op, bm, cop), "V,C", ccNext[1:0], expNx[1:0]);
    end
    @(posedge clk);
    if (fwe || cop) mCc = expNx;
  endtask

  task automatic setFlags(input bit [3:0] f);
    applyVec(0, 0, 0, 0, 0, 1, {1'b0, 4'hF});
    applyVec(0, 0, 0, 0, 0, 1, {1'b1, f});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(ccFlags == 4'b0000, "R11", "reset ccFlags", ccFlags, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R1 / R2 two-operand corners
    applyVec(5, 'h0001, 'h7FFF, 0, 1, 0, 0);   // R2 signed overflow
    applyVec(5, 'h0001, 'hFFFF, 0, 1, 0, 0);   // R2 carry, zero
    applyVec(6, 'h0001, 'h0000, 0, 1, 0, 0);   // R2 borrow
    applyVec(1, 'h0001, 'h8000, 0, 1, 0, 0);   // R2 compare overflow
    applyVec(3, 'h00F0, 'h0FFF, 0, 1, 0, 0);   // R1 bit clear
    applyVec(0, 'h8000, 'h1234, 0, 1, 0, 0);   // R3 copy keeps C
    // R8 byte lane
    applyVec(5, 'hAA01, 'h557F, 1, 1, 0, 0);
    applyVec(6, 'h0001, 'hC300, 1, 1, 0, 0);
    // R5 unary corners
    applyVec(10, 0, 'h7FFF, 0, 1, 0, 0);
    applyVec(11, 0, 'h8000, 0, 1, 0, 0);
    applyVec(12, 0, 'h8000, 0, 1, 0, 0);
    applyVec(12, 0, 'h0000, 0, 1, 0, 0);
    setFlags(4'b0001);
    applyVec(13, 0, 'hFFFF, 0, 1, 0, 0);
    setFlags(4'b0001);
    applyVec(14, 0, 'h0000, 0, 1, 0, 0);
    applyVec(15, 0, 'h8000, 1, 1, 0, 0);
    // R6 rotates through carry
    setFlags(4'b0001);
    applyVec(16, 0, 'h0002, 0, 1, 0, 0);
    applyVec(17, 0, 'h8000, 1, 1, 0, 0);
    applyVec(18, 0, 'h8001, 0, 1, 0, 0);
    applyVec(19, 0, 'h4000, 0, 1, 0, 0);
    // R7 swap ignores byte mode
    applyVec(20, 0, 'h00FF, 1, 1, 0, 0);
    applyVec(20, 0, 'h8012, 0, 1, 0, 0);
    // R9 unused codes, R11 hold without flagWe
    applyVec(7, 'h1111, 'h2222, 0, 1, 0, 0);
    applyVec(25, 'h1111, 'h2222, 0, 1, 0, 0);
    applyVec(5, 'hFFFF, 'hFFFF, 0, 0, 0, 0);
    // R10 command overrides opSel
    applyVec(5, 1, 1, 0, 0, 1, 5'b1_1010);
    applyVec(5, 1, 1, 0, 1, 1, 5'b0_0010);

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = $urandom_range(0, 31);
      applyVec(op, $urandom_range(0, 'hFFFF), $urandom_range(0, 'hFFFF),
               $urandom_range(0, 1), ($urandom_range(0, 3) != 0),
               ($urandom_range(0, 15) == 0), 5'($urandom_range(0, 31)));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule